// File: doc/BRIEF.md
# Clock Failure Monitor with Crystal Failover

This block supervises two clocks that feed a chip's clock tree: an external crystal clock and a PLL output clock. An internal RC oscillator clock is always running and serves as the reference. Every monitored clock drives a small divider in its own domain. The top bit of each divider is carried into the reference domain through a two-flop synchronizer. In the reference domain, counters measure the gaps between toggles of that bit. A crystal clock that stops toggling, at either level, for longer than a programmable number of reference cycles is declared failed. When that happens the block latches a crystal-failure flag, raises a one-cycle event and forces the system clock select onto the RC source.

The PLL gets the same stuck test with its own limit. It also gets a rate test: toggles are counted over a fixed window of reference cycles. Too few toggles in a window means the PLL has slowed far below its expected rate, down towards the tens of kilohertz. The PLL monitor enable is a register. It is cleared by hardware when the PLL loses lock or when a low-power entry strobe arrives. Both failure flags are sticky. Each one is removed only by reset or by its own clear strobe, and the clear strobe wins over a detection in the same cycle.

All control inputs (`xtal_mon_en`, `pll_mon_wr`, `pll_mon_wdata`, `pll_on`, `pll_lock`, `lowpwr_entry` and both clear strobes) are taken as synchronous to `ref_clk`.

Top module: `clk_fail_monitor`

## Requirements
- R1: After reset, `xtal_fail_flag`, `xtal_fail_evt`, `pll_fail_flag`, `pll_fail_evt`, `sel_force_rc` and `pll_mon_en` are all 0.
- R2: While `xtal_mon_en` is 1, a crystal clock held constant low or constant high sets `xtal_fail_flag` within XTAL_STUCK_LIM+8 reference cycles. A crystal clock whose divided toggle interval stays well inside the limit never sets it.
- R3: While `xtal_mon_en` is 0, a stuck crystal clock sets neither `xtal_fail_flag` nor `xtal_fail_evt`.
- R4: `sel_force_rc` is 1 exactly while `xtal_fail_flag` is 1. The flag stays set after the crystal clock recovers, until `xtal_flag_clr` or reset.
- R5: `rc_force_on` is 1 whenever `xtal_mon_en` is 1 or `sel_force_rc` is 1, and 0 otherwise.
- R6: A cycle with `xtal_flag_clr` at 1 leaves `xtal_fail_flag` at 0 on the next cycle, even if a failure is detected in that same cycle.
- R7: `xtal_fail_evt` is high for exactly one cycle, in the cycle where `xtal_fail_flag` rises, and never while the flag was already set.
- R8: While `pll_mon_en` is 1, a stopped PLL clock sets `pll_fail_flag`.
- R9: While `pll_mon_en` is 1, a PLL clock that still toggles but gives fewer than PLL_MIN_EDGES divided toggles in a PLL_WIN-cycle window sets `pll_fail_flag`. A PLL clock at its normal rate never sets it.
- R10: A write (`pll_mon_wr`=1) sets `pll_mon_en` to `pll_mon_wdata` only when `pll_on` is 1. A write of 1 while `pll_on` is 0 leaves the enable at 0.
- R11: `lowpwr_entry` at 1, or `pll_lock` falling from 1 to 0, clears `pll_mon_en` on the next cycle. Either one wins over a write in the same cycle.
- R12: `pll_fail_flag` is sticky until `pll_flag_clr` or reset, has a one-cycle `pll_fail_evt`, and never drives `sel_force_rc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running RC reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_clk | input | 1 | Monitored crystal clock |
| pll_clk | input | 1 | Monitored PLL output clock |
| xtal_mon_en | input | 1 | Crystal monitor enable |
| pll_mon_wr | input | 1 | Write strobe for the PLL monitor enable |
| pll_mon_wdata | input | 1 | Value written to the PLL monitor enable |
| pll_on | input | 1 | PLL is switched on |
| pll_lock | input | 1 | PLL lock indication |
| lowpwr_entry | input | 1 | Strobe on entry to a low-power state |
| xtal_flag_clr | input | 1 | Clear strobe for the crystal failure flag |
| pll_flag_clr | input | 1 | Clear strobe for the PLL failure flag |
| pll_mon_en | output | 1 | Current PLL monitor enable |
| xtal_fail_flag | output | 1 | Latched crystal failure flag |
| xtal_fail_evt | output | 1 | One-cycle event when the crystal flag rises |
| pll_fail_flag | output | 1 | Latched PLL failure flag |
| pll_fail_evt | output | 1 | One-cycle event when the PLL flag rises |
| sel_force_rc | output | 1 | Forces the system clock select onto the RC source |
| rc_force_on | output | 1 | Requests the RC oscillator on |

## Verification
The assertions watch the flag bookkeeping on every cycle:
- clear priority over a detection;
- stickiness of both flags;
- the tie between each event pulse and its flag's rising edge;
- silence of the crystal event while that monitor is disabled;
- the enable register's rules for `pll_on` and low-power entry.

Whether a stuck or slowed clock is caught at all, and how soon, depends on real clock waveforms. Only the bench scenarios can show this. They stop clocks at either level, slow the PLL, and run healthy clocks at random periods. In the same way, only the scenarios can show that a healthy clock never trips the detectors.

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor #(
  parameter int XTAL_DIV_W     = 2,
  parameter int PLL_DIV_W      = 4,
  parameter int XTAL_STUCK_LIM = 64,
  parameter int PLL_STUCK_LIM  = 1024,
  parameter int PLL_WIN        = 256,
  parameter int PLL_MIN_EDGES  = 4
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic xtal_clk,
  input  logic pll_clk,
  input  logic xtal_mon_en,
  input  logic pll_mon_wr,
  input  logic pll_mon_wdata,
  input  logic pll_on,
  input  logic pll_lock,
  input  logic lowpwr_entry,
  input  logic xtal_flag_clr,
  input  logic pll_flag_clr,
  output logic pll_mon_en,
  output logic xtal_fail_flag,
  output logic xtal_fail_evt,
  output logic pll_fail_flag,
  output logic pll_fail_evt,
  output logic sel_force_rc,
  output logic rc_force_on
);
  localparam int XCW = $clog2(XTAL_STUCK_LIM);
  localparam int PCW = $clog2(PLL_STUCK_LIM);
  localparam int WW  = $clog2(PLL_WIN);
  localparam int EW  = $clog2(PLL_MIN_EDGES + 1);

  logic [XTAL_DIV_W-1:0] xdiv;
  logic [PLL_DIV_W-1:0]  pdiv;

  always_ff @(posedge xtal_clk or negedge rst_n)
    if (!rst_n) xdiv <= '0;
    else        xdiv <= xdiv + 1'b1;

  always_ff @(posedge pll_clk or negedge rst_n)
    if (!rst_n) pdiv <= '0;
    else        pdiv <= pdiv + 1'b1;

  logic [2:0] xsync, psync;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      xsync <= '0;
      psync <= '0;
    end else begin
      xsync <= {xsync[1:0], xdiv[XTAL_DIV_W-1]};
      psync <= {psync[1:0], pdiv[PLL_DIV_W-1]};
    end

  wire x_edge = xsync[2] ^ xsync[1];
  wire p_edge = psync[2] ^ psync[1];

  logic [XCW-1:0] xcnt;
  wire x_hit = xtal_mon_en && !x_edge && (xcnt == XCW'(XTAL_STUCK_LIM - 1));

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                                         xcnt <= '0;
    else if (!xtal_mon_en || x_edge || x_hit || xtal_flag_clr) xcnt <= '0;
    else                                                xcnt <= xcnt + 1'b1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      xtal_fail_flag <= 1'b0;
      xtal_fail_evt  <= 1'b0;
    end else begin
      xtal_fail_flag <= !xtal_flag_clr && (xtal_fail_flag || x_hit);
      xtal_fail_evt  <= x_hit && !xtal_flag_clr && !xtal_fail_flag;
    end

  logic lock_q;
  wire  unlock = lock_q && !pll_lock;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      lock_q     <= 1'b0;
      pll_mon_en <= 1'b0;
    end else begin
      lock_q <= pll_lock;
      if (lowpwr_entry || unlock) pll_mon_en <= 1'b0;
      else if (pll_mon_wr)        pll_mon_en <= pll_mon_wdata && pll_on;
    end

  logic [PCW-1:0] pcnt;
  wire p_stuck_hit = pll_mon_en && !p_edge && (pcnt == PCW'(PLL_STUCK_LIM - 1));

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                                                  pcnt <= '0;
    else if (!pll_mon_en || p_edge || p_stuck_hit || pll_flag_clr) pcnt <= '0;
    else                                                         pcnt <= pcnt + 1'b1;

  logic [WW-1:0] wcnt;
  logic [EW-1:0] ecnt;
  logic [EW:0]   esum;
  wire win_end = pll_mon_en && (wcnt == WW'(PLL_WIN - 1));

  assign esum = {1'b0, ecnt} + (EW+1)'(p_edge);
  wire p_slow_hit = win_end && (esum < (EW+1)'(PLL_MIN_EDGES));

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (!pll_mon_en || win_end) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
      if (p_edge && ecnt != EW'(PLL_MIN_EDGES)) ecnt <= ecnt + 1'b1;
    end

  wire p_hit = p_stuck_hit || p_slow_hit;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      pll_fail_flag <= 1'b0;
      pll_fail_evt  <= 1'b0;
    end else begin
      pll_fail_flag <= !pll_flag_clr && (pll_fail_flag || p_hit);
      pll_fail_evt  <= p_hit && !pll_flag_clr && !pll_fail_flag;
    end

  assign sel_force_rc = xtal_fail_flag;
  assign rc_force_on  = xtal_mon_en || xtal_fail_flag;
endmodule

// File: rtl/clk_fail_monitor_chk.sv
module clk_fail_monitor_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic xtal_mon_en,
  input logic pll_on,
  input logic lowpwr_entry,
  input logic xtal_flag_clr,
  input logic pll_flag_clr,
  input logic pll_mon_en,
  input logic xtal_fail_flag,
  input logic xtal_fail_evt,
  input logic pll_fail_flag,
  input logic pll_fail_evt,
  input logic sel_force_rc,
  input logic rc_force_on
);
  p_clear_wins_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    xtal_flag_clr |=> !xtal_fail_flag);

  p_sticky_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    xtal_fail_flag && !xtal_flag_clr |=> xtal_fail_flag);

  p_evt_on_rise_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(xtal_fail_flag) |-> xtal_fail_evt);

  p_evt_fresh_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    xtal_fail_evt |-> xtal_fail_flag && !$past(xtal_fail_flag));

  p_quiet_disabled_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !xtal_mon_en |=> !xtal_fail_evt);

  p_rc_on_override_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_force_rc |-> rc_force_on);

  p_no_set_pll_off_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pll_mon_en && !pll_on |=> !pll_mon_en);

  p_lowpwr_clear_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lowpwr_entry |=> !pll_mon_en);

  p_pll_sticky_r12: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_fail_flag && !pll_flag_clr |=> pll_fail_flag);

  p_pll_evt_r12: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_fail_evt |-> pll_fail_flag && !$past(pll_fail_flag));
endmodule

bind clk_fail_monitor clk_fail_monitor_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .xtal_mon_en(xtal_mon_en), .pll_on(pll_on),
  .lowpwr_entry(lowpwr_entry), .xtal_flag_clr(xtal_flag_clr), .pll_flag_clr(pll_flag_clr),
  .pll_mon_en(pll_mon_en), .xtal_fail_flag(xtal_fail_flag), .xtal_fail_evt(xtal_fail_evt),
  .pll_fail_flag(pll_fail_flag), .pll_fail_evt(pll_fail_evt),
  .sel_force_rc(sel_force_rc), .rc_force_on(rc_force_on)
);

// File: tb/clk_fail_monitor_tb.sv
`timescale 1ns/1ps
module clk_fail_monitor_tb;
  localparam int XLIM = 64;

  logic ref_clk = 0, rst_n = 0, xtal_clk = 0, pll_clk = 0;
  logic xtal_mon_en = 0, pll_mon_wr = 0, pll_mon_wdata = 0, pll_on = 0, pll_lock = 0;
  logic lowpwr_entry = 0, xtal_flag_clr = 0, pll_flag_clr = 0;
  logic pll_mon_en, xtal_fail_flag, xtal_fail_evt, pll_fail_flag, pll_fail_evt;
  logic sel_force_rc, rc_force_on;

  int checks = 0, errors = 0, cyc = 0;
  int xtal_half = 20, pll_half = 5;
  logic xtal_run = 1, xtal_lvl = 0, pll_run = 1, pll_lvl = 0;

  clk_fail_monitor u_dut (.*);

  always #2 ref_clk = ~ref_clk;
  always begin #(xtal_half); if (xtal_run) xtal_clk = ~xtal_clk; else xtal_clk = xtal_lvl; end
  always begin #(pll_half);  if (pll_run)  pll_clk  = ~pll_clk;  else pll_clk  = pll_lvl;  end

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic exp_rc_on(logic en, logic flag);
    return en | flag;
  endfunction
  function automatic logic exp_xflag(logic en, logic stuck, logic clr_held);
    return en & stuck & ~clr_held;
  endfunction
  function automatic logic exp_pmon(logic cur, logic wr, logic d, logic on, logic lp, logic unl);
    if (lp || unl) return 1'b0;
    if (wr) return d & on;
    return cur;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic clr_xtal();
    @(negedge ref_clk) xtal_flag_clr = 1;
    @(negedge ref_clk) xtal_flag_clr = 0;
  endtask

  task automatic write_pmon(logic d, logic lp);
    logic e;
    e = exp_pmon(pll_mon_en, 1'b1, d, pll_on, lp, 1'b0);
    @(negedge ref_clk) begin pll_mon_wr = 1; pll_mon_wdata = d; lowpwr_entry = lp; end
    @(negedge ref_clk) begin pll_mon_wr = 0; lowpwr_entry = 0; end
    chk(lp ? "R11 lowpwr beats write" : "R10 pll monitor write", pll_mon_en, e);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc_wait(3);
    chk("R1 reset xtal flag", xtal_fail_flag, 0);
    chk("R1 reset pll flag", pll_fail_flag, 0);
    chk("R1 reset override", sel_force_rc, 0);
    chk("R1 reset pll enable", pll_mon_en, 0);
    @(negedge ref_clk) rst_n = 1;
    cyc_wait(50);

    // R2 / R3 / R5 / R7: random crystal scenarios
    for (int i = 0; i < 24; i++) begin
      int mode, nevt;
      logic en, stuck;
      mode = $urandom_range(0, 2);
      en = 1'($urandom_range(0, 1));
      stuck = (mode != 0);
      xtal_half = $urandom_range(8, 28);
      xtal_run = 1;
      @(negedge ref_clk) xtal_mon_en = 0;
      cyc_wait(40);
      clr_xtal();
      @(negedge ref_clk) xtal_mon_en = en;
      cyc_wait(40);
      chk("R2 healthy crystal no flag", xtal_fail_flag, 0);
      xtal_lvl = (mode == 2);
      xtal_run = !stuck;
      nevt = 0;
      for (int k = 0; k < 3 * XLIM; k++) begin
        @(negedge ref_clk);
        if (xtal_fail_evt) nevt++;
      end
      chk(en ? "R2 crystal stuck detect" : "R3 disabled monitor", xtal_fail_flag,
          exp_xflag(en, stuck, 1'b0));
      chk_int("R7 single event pulse", nevt, int'(exp_xflag(en, stuck, 1'b0)));
      chk("R4 override follows flag", sel_force_rc, exp_xflag(en, stuck, 1'b0));
      chk("R5 rc force on", rc_force_on, exp_rc_on(en, exp_xflag(en, stuck, 1'b0)));
    end

    // R2 bound, R4 sticky after recovery, then clear
    xtal_run = 1; xtal_half = 20;
    @(negedge ref_clk) xtal_mon_en = 0;
    cyc_wait(40); clr_xtal();
    @(negedge ref_clk) xtal_mon_en = 1;
    cyc_wait(40);
    xtal_lvl = 1; xtal_run = 0;
    cyc_wait(XLIM + 8);
    chk("R2 detect within bound (stuck high)", xtal_fail_flag, 1);
    xtal_run = 1;
    cyc_wait(200);
    chk("R4 flag sticky after recovery", xtal_fail_flag, 1);
    chk("R4 override sticky", sel_force_rc, 1);
    clr_xtal();
    chk("R4 clear removes flag", xtal_fail_flag, 0);
    chk("R4 clear removes override", sel_force_rc, 0);
    chk("R5 rc on while enabled", rc_force_on, 1);

    // R6: clear held during a stuck clock
    xtal_lvl = 0; xtal_run = 0;
    @(negedge ref_clk) xtal_flag_clr = 1;
    begin
      int nevt = 0;
      for (int k = 0; k < 3 * XLIM; k++) begin
        @(negedge ref_clk);
        if (xtal_fail_evt) nevt++;
      end
      chk("R6 clear wins over detection", xtal_fail_flag, exp_xflag(1, 1, 1));
      chk_int("R6 no event under clear", nevt, 0);
    end
    @(negedge ref_clk) xtal_flag_clr = 0;
    cyc_wait(XLIM + 8);
    chk("R6 detect after clear released", xtal_fail_flag, 1);

    // R1: reset mid-run
    @(negedge ref_clk) rst_n = 0;
    @(negedge ref_clk);
    chk("R1 reset clears flag", xtal_fail_flag, 0);
    @(negedge ref_clk) begin rst_n = 1; xtal_mon_en = 0; end
    xtal_run = 1;
    cyc_wait(20);
    chk("R5 rc off when idle", rc_force_on, exp_rc_on(0, 0));

    // R10 / R11: PLL monitor enable
    write_pmon(1, 0);
    chk("R10 no set while pll off", pll_mon_en, 0);
    @(negedge ref_clk) begin pll_on = 1; pll_lock = 1; end
    write_pmon(1, 0);
    chk("R10 set while pll on", pll_mon_en, 1);
    write_pmon(0, 0);
    write_pmon(1, 0);
    @(negedge ref_clk) lowpwr_entry = 1;
    @(negedge ref_clk) lowpwr_entry = 0;
    chk("R11 lowpwr clears enable", pll_mon_en, 0);
    write_pmon(1, 1);
    write_pmon(1, 0);
    @(negedge ref_clk) pll_lock = 0;
    @(negedge ref_clk);
    chk("R11 unlock clears enable", pll_mon_en, 0);
    @(negedge ref_clk) pll_lock = 1;
    write_pmon(1, 0);

    // R9 healthy, R9 slow, R8 stuck, R12
    cyc_wait(1200);
    chk("R9 healthy pll no flag", pll_fail_flag, 0);
    pll_half = 100;
    cyc_wait(700);
    chk("R9 slow pll detected", pll_fail_flag, 1);
    chk("R12 pll flag no override", sel_force_rc, 0);
    pll_half = 5;
    cyc_wait(600);
    chk("R12 pll flag sticky", pll_fail_flag, 1);
    @(negedge ref_clk) pll_flag_clr = 1;
    @(negedge ref_clk) pll_flag_clr = 0;
    chk("R12 pll flag cleared", pll_fail_flag, 0);
    cyc_wait(600);
    chk("R9 healthy after clear", pll_fail_flag, 0);
    pll_lvl = 1; pll_run = 0;
    begin
      int nevt = 0;
      for (int k = 0; k < 1300; k++) begin
        @(negedge ref_clk);
        if (pll_fail_evt) nevt++;
      end
      chk("R8 stuck pll detected", pll_fail_flag, 1);
      chk_int("R12 single pll event", nevt, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule